// File: doc/BRIEF.md
# Accumulator Address Selector with Counting Source

This block forms the 4-bit address that picks one of sixteen fast accumulator registers. Each cycle a 2-bit select code picks where the address comes from. It can come from the accumulator field of the current instruction word or from that word's index field. It can also come from the low bits of the memory address register, or from a small counter register held inside the block. The address is combinational from the current inputs and the current counter value. This lets the register file read or write it in the same cycle.

The counter source supports block transfers across the accumulators. It can be cleared or loaded from the low bits of the data bus. An increment strobe steps it after each access, so a run of accesses walks through consecutive accumulators. The block also decodes three conditions for a sequencer to branch on:
- the memory address lies inside the accumulator range;
- the instruction's accumulator field is zero;
- the instruction uses indexing or indirection.

The instruction word uses big-endian bit numbering. Bit 0 is the most significant of 36 bits, which is `ir_i[35]`.

Top module: `ac_addr_sel`

## Requirements
- R1: With `sel_i` = 0 the address is the accumulator field, instruction bits 9..12 (bit 0 = MSB), which is `ir_i[26:23]`.
- R2: With `sel_i` = 1 the address is the index field, instruction bits 14..17, which is `ir_i[21:18]`.
- R3: With `sel_i` = 2 the address is `ma_i[3:0]`.
- R4: With `sel_i` = 3 the address is the counter value in that same cycle.
- R5: `cnt_clr_i` zeroes the counter at the next rising clock edge. It overrides load and increment.
- R6: `cnt_load_i` (without clear) loads `bus_i` into the counter at the next edge. It overrides increment.
- R7: `cnt_inc_i` alone advances the counter by one at the next edge, wrapping from 15 to 0. The address seen during the strobe cycle is the value before the increment.
- R8: With no strobe the counter holds. An active-low asynchronous reset sets it to 0.
- R9: `ma_in_ac_o` is 1 exactly when the whole 18-bit `ma_i` is below 16. Any upper bit set clears it, even when the low four bits are all ones.
- R10: `ac_zero_o` is 1 exactly when `ir_i[26:23]` is zero, whatever `sel_i` is.
- R11: `idx_ind_o` is 1 when `ir_i[21:18]` is nonzero or the indirect bit `ir_i[22]` (instruction bit 13) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Address source: 0 acc field, 1 index field, 2 memory address, 3 counter |
| ir_i | input | 36 | Instruction word, bit 0 = MSB = ir_i[35] |
| ma_i | input | 18 | Memory address register |
| bus_i | input | 4 | Low bits of the data bus, load value for the counter |
| cnt_clr_i | input | 1 | Clear counter |
| cnt_load_i | input | 1 | Load counter from bus_i |
| cnt_inc_i | input | 1 | Advance counter after this access |
| ac_addr_o | output | 4 | Selected accumulator address |
| ma_in_ac_o | output | 1 | Memory address is below 16 |
| ac_zero_o | output | 1 | Accumulator field is zero |
| idx_ind_o | output | 1 | Index field nonzero or indirect bit set |

## Verification
The bench walks a lone one and a lone zero through every instruction bit. A field taken one position off would then return a wrong address or raise a condition from a neighbouring bit. It tests memory addresses 15, 16, 0x1F and lone upper bits. A range check that looked only at the low bits would wrongly report 0x1F as an accumulator address. It runs the counter through a wrap from 15 to 0 and asserts clear, load and increment together. A wrong priority or a carry that leaked past four bits would show as a wrong counter address on the next cycle.

// File: rtl/ac_sel_pkg.sv
package ac_sel_pkg;
  typedef enum logic [1:0] {
    SRC_ACF = 2'd0,
    SRC_IDX = 2'd1,
    SRC_MA  = 2'd2,
    SRC_CNT = 2'd3
  } ac_src_e;
endpackage

// File: rtl/ac_ir_fields.sv
module ac_ir_fields #(
  parameter int WORD_W  = 36,
  parameter int OPC_W   = 9,
  parameter int AC_W    = 4,
  parameter int IDX_END = 17   // big-endian position of index LSB
) (
  input  logic [WORD_W-1:0] ir_i,
  output logic [AC_W-1:0]   acf_o,
  output logic [AC_W-1:0]   idx_o,
  output logic              ac_zero_o,
  output logic              idx_ind_o
);
  localparam int AcLsb  = WORD_W - OPC_W - AC_W;
  localparam int IdxLsb = WORD_W - 1 - IDX_END;
  localparam int IndBit = IdxLsb + AC_W;

  logic ind;
  logic unused_ir;

  assign acf_o     = ir_i[AcLsb +: AC_W];
  assign idx_o     = ir_i[IdxLsb +: AC_W];
  assign ind       = ir_i[IndBit];
  assign ac_zero_o = (acf_o == '0);
  assign idx_ind_o = ind | (|idx_o);
  assign unused_ir = ^{ir_i[WORD_W-1:AcLsb+AC_W], ir_i[IdxLsb-1:0]};
endmodule

// File: rtl/ac_cnt.sv
module ac_cnt #(
  parameter int AC_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic            inc_i,
  input  logic [AC_W-1:0] load_val_i,
  output logic [AC_W-1:0] cnt_o
);
  logic [AC_W-1:0] cnt_d, cnt_q;

  // clear > load > increment
  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (load_i) cnt_d = load_val_i;
    else if (inc_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ac_src_mux.sv
module ac_src_mux
  import ac_sel_pkg::*;
#(
  parameter int AC_W = 4
) (
  input  ac_src_e         sel_i,
  input  logic [AC_W-1:0] acf_i,
  input  logic [AC_W-1:0] idx_i,
  input  logic [AC_W-1:0] ma_lo_i,
  input  logic [AC_W-1:0] cnt_i,
  output logic [AC_W-1:0] addr_o
);
  always_comb begin
    unique case (sel_i)
      SRC_ACF: addr_o = acf_i;
      SRC_IDX: addr_o = idx_i;
      SRC_MA:  addr_o = ma_lo_i;
      default: addr_o = cnt_i;
    endcase
  end
endmodule

// File: rtl/ac_addr_sel.sv
module ac_addr_sel
  import ac_sel_pkg::*;
#(
  parameter int WORD_W  = 36,
  parameter int OPC_W   = 9,
  parameter int AC_W    = 4,
  parameter int MA_W    = 18,
  parameter int IDX_END = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_i,
  input  logic [WORD_W-1:0] ir_i,
  input  logic [MA_W-1:0]   ma_i,
  input  logic [AC_W-1:0]   bus_i,
  input  logic              cnt_clr_i,
  input  logic              cnt_load_i,
  input  logic              cnt_inc_i,
  output logic [AC_W-1:0]   ac_addr_o,
  output logic              ma_in_ac_o,
  output logic              ac_zero_o,
  output logic              idx_ind_o
);
  logic [AC_W-1:0] acf, idx, cnt_q;

  ac_ir_fields #(
    .WORD_W(WORD_W), .OPC_W(OPC_W), .AC_W(AC_W), .IDX_END(IDX_END)
  ) u_fields (
    .ir_i      (ir_i),
    .acf_o     (acf),
    .idx_o     (idx),
    .ac_zero_o (ac_zero_o),
    .idx_ind_o (idx_ind_o)
  );

  ac_cnt #(.AC_W(AC_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cnt_clr_i),
    .load_i     (cnt_load_i),
    .inc_i      (cnt_inc_i),
    .load_val_i (bus_i),
    .cnt_o      (cnt_q)
  );

  ac_src_mux #(.AC_W(AC_W)) u_mux (
    .sel_i   (ac_src_e'(sel_i)),
    .acf_i   (acf),
    .idx_i   (idx),
    .ma_lo_i (ma_i[AC_W-1:0]),
    .cnt_i   (cnt_q),
    .addr_o  (ac_addr_o)
  );

  // in range only if every bit above the accumulator address is clear
  assign ma_in_ac_o = ~(|ma_i[MA_W-1:AC_W]);
endmodule

// File: rtl/ac_addr_sel_chk.sv
module ac_addr_sel_chk #(
  parameter int AC_W = 4,
  parameter int MA_W = 18
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      sel_i,
  input logic [MA_W-1:0] ma_i,
  input logic [AC_W-1:0] bus_i,
  input logic            cnt_clr_i,
  input logic            cnt_load_i,
  input logic            cnt_inc_i,
  input logic [AC_W-1:0] ac_addr_o,
  input logic            ma_in_ac_o,
  input logic            ac_zero_o,
  input logic            idx_ind_o,
  input logic [AC_W-1:0] cnt_q
);
  assert_cnt_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd3) |-> (ac_addr_o == cnt_q));

  assert_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_q == '0));

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && cnt_load_i) |=> (cnt_q == $past(bus_i)));

  assert_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && !cnt_load_i && cnt_inc_i) |=> (cnt_q == AC_W'($past(cnt_q) + 1'b1)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && !cnt_load_i && !cnt_inc_i) |=> $stable(cnt_q));

  assert_ma_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ma_i[MA_W-1:AC_W] != '0) |-> !ma_in_ac_o);

  assert_ma_in_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ma_in_ac_o && sel_i == 2'd2) |-> (ac_addr_o == ma_i[AC_W-1:0]));

  assert_ac_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ac_zero_o && sel_i == 2'd0) |-> (ac_addr_o == '0));

  assert_idx_ind_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd1 && ac_addr_o != '0) |-> idx_ind_o);
endmodule

bind ac_addr_sel ac_addr_sel_chk #(.AC_W(AC_W), .MA_W(MA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .ma_i       (ma_i),
  .bus_i      (bus_i),
  .cnt_clr_i  (cnt_clr_i),
  .cnt_load_i (cnt_load_i),
  .cnt_inc_i  (cnt_inc_i),
  .ac_addr_o  (ac_addr_o),
  .ma_in_ac_o (ma_in_ac_o),
  .ac_zero_o  (ac_zero_o),
  .idx_ind_o  (idx_ind_o),
  .cnt_q      (cnt_q)
);

// File: tb/ac_addr_sel_tb.sv
`timescale 1ns/1ps
module ac_addr_sel_tb;
  localparam int PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  sel = '0;
  logic [35:0] ir = '0;
  logic [17:0] ma = '0;
  logic [3:0]  bus = '0;
  logic        clr = 1'b0, ld = 1'b0, inc = 1'b0;
  logic [3:0]  addr;
  logic        ma_in, ac_zero, idx_ind;

  int checks = 0;
  int failures = 0;
  int m_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  ac_addr_sel u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .ir_i(ir), .ma_i(ma),
    .bus_i(bus), .cnt_clr_i(clr), .cnt_load_i(ld), .cnt_inc_i(inc),
    .ac_addr_o(addr), .ma_in_ac_o(ma_in), .ac_zero_o(ac_zero),
    .idx_ind_o(idx_ind)
  );

  // reference counter
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  m_cnt <= 0;
    else if (clr) m_cnt <= 0;
    else if (ld)  m_cnt <= int'(bus);
    else if (inc) m_cnt <= (m_cnt + 1) % 16;
  end

  // instruction bit n counted from the left (bit 0 = MSB)
  function automatic int ir_bits(logic [35:0] w, int first, int n);
    int v = 0;
    for (int k = first; k < first + n; k++) v = v * 2 + int'(w[35-k]);
    return v;
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    int e_addr, acf, idxf;
    acf  = ir_bits(ir, 9, 4);
    idxf = ir_bits(ir, 14, 4);
    case (sel)
      2'd0: e_addr = acf;
      2'd1: e_addr = idxf;
      2'd2: e_addr = int'(ma) % 16;
      default: e_addr = m_cnt;
    endcase
    chk(tag, "addr", int'(addr), e_addr);
    chk("R9", "ma_in_ac", int'(ma_in), (int'(ma) < 16) ? 1 : 0);
    chk("R10", "ac_zero", int'(ac_zero), (acf == 0) ? 1 : 0);
    chk("R11", "idx_ind", int'(idx_ind),
        (idxf != 0 || ir_bits(ir, 13, 1) != 0) ? 1 : 0);
  endtask

  task automatic step(string tag, logic [1:0] s, logic [35:0] w, logic [17:0] m,
                      logic [3:0] b, logic c, logic l, logic i);
    @(negedge clk);
    sel = s; ir = w; ma = m; bus = b; clr = c; ld = l; inc = i;
    #2;
    compare(tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 3 + 3);
    // reset state R8
    sel = 2'd3; #1;
    chk("R8", "reset addr", int'(addr), 0);
    @(negedge clk); rst_ni = 1'b1;

    // lone one and lone zero through the instruction word: R1 R2 R10 R11
    for (int b = 0; b < 36; b++) begin
      logic [35:0] w1;
      w1 = 36'd1 << b;
      step("R1", 2'd0, w1, 18'd0, 4'd0, 1'b0, 1'b0, 1'b0);
      step("R2", 2'd1, w1, 18'd0, 4'd0, 1'b0, 1'b0, 1'b0);
      step("R1", 2'd0, ~w1, 18'd0, 4'd0, 1'b0, 1'b0, 1'b0);
      step("R2", 2'd1, ~w1, 18'd0, 4'd0, 1'b0, 1'b0, 1'b0);
    end

    // memory address source and range boundary: R3 R9
    step("R3", 2'd2, 36'd0, 18'd15, 4'd0, 1'b0, 1'b0, 1'b0);
    step("R3", 2'd2, 36'd0, 18'd16, 4'd0, 1'b0, 1'b0, 1'b0);
    step("R3", 2'd2, 36'd0, 18'h1F, 4'd0, 1'b0, 1'b0, 1'b0);
    step("R3", 2'd2, 36'd0, 18'd0, 4'd0, 1'b0, 1'b0, 1'b0);
    for (int b = 4; b < 18; b++)
      step("R9", 2'd2, 36'd0, (18'd1 << b) | 18'hF, 4'd0, 1'b0, 1'b0, 1'b0);

    // counter: clear, increment through wrap, load, priorities
    step("R5", 2'd3, 36'd0, 18'd0, 4'd0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 20; k++)
      step("R7", 2'd3, 36'd0, 18'd0, 4'd0, 1'b0, 1'b0, 1'b1);
    step("R6", 2'd3, 36'd0, 18'd0, 4'hE, 1'b0, 1'b1, 1'b1);
    step("R7", 2'd3, 36'd0, 18'd0, 4'd0, 1'b0, 1'b0, 1'b1);
    step("R7", 2'd3, 36'd0, 18'd0, 4'd0, 1'b0, 1'b0, 1'b1);
    step("R7", 2'd3, 36'd0, 18'd0, 4'd0, 1'b0, 1'b0, 1'b0);
    step("R8", 2'd3, 36'd0, 18'd0, 4'd9, 1'b0, 1'b0, 1'b0);
    step("R8", 2'd0, 36'd0, 18'd0, 4'd9, 1'b0, 1'b0, 1'b0);
    step("R4", 2'd3, 36'd0, 18'd0, 4'd9, 1'b1, 1'b1, 1'b1);
    step("R5", 2'd3, 36'd0, 18'd0, 4'd7, 1'b0, 1'b1, 1'b0);
    step("R6", 2'd3, 36'd0, 18'd0, 4'd0, 1'b0, 1'b0, 1'b0);
    // counter advances while another source is selected
    step("R7", 2'd2, 36'd0, 18'd3, 4'd0, 1'b0, 1'b0, 1'b1);
    step("R4", 2'd3, 36'd0, 18'd3, 4'd0, 1'b0, 1'b0, 1'b0);

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [17:0] m;
      m = ($urandom_range(0, 1) == 0) ? 18'($urandom_range(0, 31)) : 18'($urandom);
      step("R4", 2'($urandom), {4'($urandom), 32'($urandom)}, m, 4'($urandom),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 1) == 0));
    end

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule